// File: doc/BRIEF.md
# SHA-256 Message Schedule Expander

This block produces the sixty-four 32-bit schedule words of one 512-bit SHA-256 block, one word per accepted advance pulse. It is fed by a padding stage that presents a complete block with a load strobe, and it is read by a compression round engine that pulses the advance input each time it needs the next word. Every issued word comes with its round index, so the round engine can pick the matching round constant without keeping its own count.

The first sixteen words come straight from the block. Each later word is computed when it is issued, from four earlier words, using the two small sigma functions. Only sixteen words are stored. They sit in a circular buffer, and each new word overwrites the oldest slot, which no later word needs. A flag marks that the last word of the block has been issued. Issuing then stops until the next load.

Top module: `sha256_sched_gen`

## Requirements
- R1: After reset, word_vld_o and done_o are 0, idx_o is 0 and word_o is 0.
- R2: After a load, the first sixteen words issued equal the block split big-endian: word 0 is block_i[511:480], word 1 is block_i[479:448], and so on down to word 15 at block_i[31:0].
- R3: For index t from 16 to 63, the word issued is s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] modulo 2^32. Here s0(x) = rotr(x,7) ^ rotr(x,18) ^ (x >> 3) and s1(x) = rotr(x,17) ^ rotr(x,19) ^ (x >> 10).
- R4: Each accepted advance, sampled at a clock edge, issues exactly one word. From that same edge, word_vld_o is 1 for one cycle and idx_o holds the index of the word. Successive words carry indices that rise by one.
- R5: In a cycle with no advance, word_vld_o is 0 and word_o and idx_o keep their values.
- R6: done_o rises on the edge that issues index 63, together with that word, and it stays 1 until the next load.
- R7: Once index 63 has been issued, further advances issue nothing: word_vld_o stays 0 and word_o and idx_o hold.
- R8: Advances before the first load after reset issue nothing.
- R9: A load at any point, including in the middle of a block, clears done_o and restarts the sequence at index 0. The following words are all derived from the new block.
- R10: When load and advance are high on the same edge, the load takes effect and no word is issued on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe: capture block_i and restart at index 0 |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| adv_i | input | 1 | Advance: issue the next schedule word |
| word_o | output | 32 | Last issued schedule word |
| idx_o | output | 6 | Round index of word_o |
| word_vld_o | output | 1 | High for one cycle when a new word is issued |
| done_o | output | 1 | Index 63 has been issued for the current block |

## Verification
The hardest situation to reach is a reload partway through the expanded region. At that point the ring buffer already holds a mix of overwritten computed words and original block words, and any slot left stale would corrupt the words that follow. The bench advances twenty words into one block, so that four slots have been rewritten. It then loads a different block and compares all sixty-four words against a model computed from the new block alone. It also puts load and advance on the same edge, both right after a finished block and in the middle of one, to show that the load wins and that no stale word leaks out.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotr(input word_t x, input int unsigned n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    // lower-case sigma 0 of the schedule recurrence
    function automatic word_t small_s0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    // lower-case sigma 1 of the schedule recurrence
    function automatic word_t small_s1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

endpackage

// File: rtl/sched_ring.sv
module sched_ring
    import sched_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int NRD    = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BLK_W  = SLOTS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BLK_W-1:0]  block_i,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_addr_i,
    input  word_t             wr_data_i,
    input  logic [SLOT_W-1:0] rd_addr_i [NRD],
    output word_t             rd_data_o [NRD]
);

    word_t slots_d [SLOTS];
    word_t slots_q [SLOTS];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            slots_d[i] = slots_q[i];
        end
        if (load_i) begin
            // big-endian split: slot 0 takes the most significant word
            for (int i = 0; i < SLOTS; i++) begin
                slots_d[i] = block_i[BLK_W-1-i*WORD_W -: WORD_W];
            end
        end else if (wr_en_i) begin
            slots_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                slots_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                slots_q[i] <= slots_d[i];
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data_o[g] = slots_q[rd_addr_i[g]];
    end

endmodule

// File: rtl/sched_mix.sv
module sched_mix
    import sched_pkg::*;
(
    input  word_t w_m2_i,
    input  word_t w_m7_i,
    input  word_t w_m15_i,
    input  word_t w_m16_i,
    output word_t w_new_o
);

    always_comb begin
        w_new_o = small_s1(w_m2_i) + w_m7_i + small_s0(w_m15_i) + w_m16_i;
    end

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl #(
    parameter int ROUNDS = 64,
    localparam int IDX_W = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             issue_o,
    output logic             done_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             active;
        logic             done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        issue_o = 1'b0;
        if (load_i) begin
            st_d.idx    = '0;
            st_d.active = 1'b1;
            st_d.done   = 1'b0;
        end else if (adv_i && st_q.active) begin
            issue_o = 1'b1;
            if (st_q.idx == IDX_W'(ROUNDS - 1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o  = st_q.idx;
    assign done_o = st_q.done;

endmodule

// File: rtl/sha256_sched_gen.sv
module sha256_sched_gen
    import sched_pkg::*;
#(
    parameter int BLK_WORDS = 16,
    parameter int ROUNDS    = 64,
    localparam int IDX_W    = $clog2(ROUNDS),
    localparam int SLOT_W   = $clog2(BLK_WORDS),
    localparam int BLK_W    = BLK_WORDS * WORD_W,
    localparam int NTAP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BLK_W-1:0]  block_i,
    input  logic              adv_i,
    output logic [WORD_W-1:0] word_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              word_vld_o,
    output logic              done_o
);

    // tap distances back from the current index: t, t-2, t-7, t-15
    localparam int TAP_OFF [NTAP] = '{0, 2, 7, 15};

    typedef struct packed {
        word_t            word;
        logic [IDX_W-1:0] idx;
        logic             vld;
    } out_t;

    logic [IDX_W-1:0]  cur_idx;
    logic              issue;
    logic              done_st;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] rd_addr [NTAP];
    word_t             rd_data [NTAP];
    word_t             w_new;
    word_t             w_pick;
    logic              expand;
    out_t              out_d, out_q;

    sched_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .idx_o   (cur_idx),
        .issue_o (issue),
        .done_o  (done_st)
    );

    assign slot   = cur_idx[SLOT_W-1:0];
    assign expand = (cur_idx >= IDX_W'(BLK_WORDS));

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign rd_addr[g] = slot - SLOT_W'(TAP_OFF[g]);
    end

    sched_ring #(.SLOTS(BLK_WORDS), .NRD(NTAP)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .block_i   (block_i),
        .wr_en_i   (issue && expand),
        .wr_addr_i (slot),
        .wr_data_i (w_new),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    sched_mix u_mix (
        .w_m2_i  (rd_data[1]),
        .w_m7_i  (rd_data[2]),
        .w_m15_i (rd_data[3]),
        .w_m16_i (rd_data[0]),
        .w_new_o (w_new)
    );

    assign w_pick = expand ? w_new : rd_data[0];

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (issue) begin
            out_d.word = w_pick;
            out_d.idx  = cur_idx;
            out_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o     = out_q.word;
    assign idx_o      = out_q.idx;
    assign word_vld_o = out_q.vld;
    assign done_o     = done_st;

endmodule

// File: rtl/sched_gen_chk.sv
module sched_gen_chk #(
    parameter int ROUNDS = 64,
    localparam int IDX_W = $clog2(ROUNDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             adv_i,
    input logic [31:0]      word_o,
    input logic [IDX_W-1:0] idx_o,
    input logic             word_vld_o,
    input logic             done_o
);

    // R4: a word appears only after an advance without a load
    p_vld_from_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> ($past(adv_i) && !$past(load_i)));

    // R4: back-to-back words carry consecutive indices
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_o && $past(word_vld_o)) |-> (idx_o == $past(idx_o) + 1'b1));

    // R5: outputs hold while no word is issued
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> ($stable(word_o) && $stable(idx_o)));

    // R6: done rises together with the last word
    p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (word_vld_o && idx_o == IDX_W'(ROUNDS - 1)));

    // R6: done holds until a load
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> done_o);

    // R7: nothing is issued once done
    p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !word_vld_o);

    // R9 and R10: a load clears done and issues no word
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!done_o && !word_vld_o));

endmodule

bind sha256_sched_gen sched_gen_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .adv_i      (adv_i),
    .word_o     (word_o),
    .idx_o      (idx_o),
    .word_vld_o (word_vld_o),
    .done_o     (done_o)
);

// File: tb/sha256_sched_gen_test.sv
module sha256_sched_gen_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [511:0] block_i = '0;
    logic         adv_i = 1'b0;
    logic [31:0]  word_o;
    logic [5:0]   idx_o;
    logic         word_vld_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;
    logic [31:0] ref_w [64];

    always #2 clk = ~clk;

    sha256_sched_gen uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .block_i(block_i),
        .adv_i(adv_i), .word_o(word_o), .idx_o(idx_o),
        .word_vld_o(word_vld_o), .done_o(done_o)
    );

    function automatic logic [31:0] ror(input logic [31:0] x, input int n);
        logic [63:0] dbl;
        dbl = {x, x} >> n;
        return dbl[31:0];
    endfunction

    task automatic calc_ref(input logic [511:0] blk);
        for (int i = 0; i < 16; i++) ref_w[i] = blk[511-32*i -: 32];
        for (int t = 16; t < 64; t++) begin
            ref_w[t] = (ror(ref_w[t-2], 17) ^ ror(ref_w[t-2], 19) ^ (ref_w[t-2] >> 10))
                     + ref_w[t-7]
                     + (ror(ref_w[t-15], 7) ^ ror(ref_w[t-15], 18) ^ (ref_w[t-15] >> 3))
                     + ref_w[t-16];
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: inputs set after a falling edge, outputs sampled at the next falling edge
    task automatic cyc(input bit ld, input bit adv);
        load_i = ld;
        adv_i  = adv;
        @(negedge clk);
        load_i = 1'b0;
        adv_i  = 1'b0;
    endtask

    task automatic do_load(input logic [511:0] blk);
        block_i = blk;
        cyc(1'b1, 1'b0);
        calc_ref(blk);
    endtask

    task automatic issue_check(input int t, input string req);
        cyc(1'b0, 1'b1);
        chk(word_vld_o == 1'b1, "R4 vld", 64'(word_vld_o), 64'd1);
        chk(idx_o == 6'(t), "R4 idx", 64'(idx_o), 64'(t));
        chk(word_o == ref_w[t], req, 64'(word_o), 64'(ref_w[t]));
        chk(done_o == (t == 63), "R6 done", 64'(done_o), 64'(t == 63));
    endtask

    function automatic logic [511:0] mk_block(input logic [31:0] seed);
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[511-32*i -: 32] = (seed * 32'(i + 1)) ^ {seed[15:0], 16'(i)};
        return b;
    endfunction

    task automatic t_reset;
        chk(word_vld_o == 1'b0, "R1 vld", 64'(word_vld_o), 64'd0);
        chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'd0);
        chk(idx_o == 6'd0, "R1 idx", 64'(idx_o), 64'd0);
        chk(word_o == 32'd0, "R1 word", 64'(word_o), 64'd0);
    endtask

    task automatic t_before_load;
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1);
            chk(word_vld_o == 1'b0, "R8 vld", 64'(word_vld_o), 64'd0);
            chk(idx_o == 6'd0 && word_o == 32'd0, "R8 hold", 64'(word_o), 64'd0);
        end
    endtask

    task automatic t_full_block(input logic [511:0] blk);
        do_load(blk);
        for (int t = 0; t < 64; t++) issue_check(t, t < 16 ? "R2 word" : "R3 word");
    endtask

    task automatic t_after_done;
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1);
            chk(word_vld_o == 1'b0, "R7 vld", 64'(word_vld_o), 64'd0);
            chk(word_o == ref_w[63], "R7 word", 64'(word_o), 64'(ref_w[63]));
            chk(idx_o == 6'd63, "R7 idx", 64'(idx_o), 64'd63);
            chk(done_o == 1'b1, "R6 sticky", 64'(done_o), 64'd1);
        end
    endtask

    task automatic t_gapped(input logic [511:0] blk);
        do_load(blk);
        for (int t = 0; t < 64; t++) begin
            issue_check(t, t < 16 ? "R2 gapped" : "R3 gapped");
            for (int g = 0; g < (t % 3); g++) begin
                cyc(1'b0, 1'b0);
                chk(word_vld_o == 1'b0, "R5 vld", 64'(word_vld_o), 64'd0);
                chk(word_o == ref_w[t] && idx_o == 6'(t), "R5 hold", 64'(word_o), 64'(ref_w[t]));
            end
        end
    endtask

    task automatic t_mid_reload;
        do_load(mk_block(32'h1234_5679));
        for (int t = 0; t < 20; t++) issue_check(t, "R3 pre");
        do_load(mk_block(32'hcafe_f00d));
        chk(done_o == 1'b0 && word_vld_o == 1'b0, "R9 load", 64'({done_o, word_vld_o}), 64'd0);
        for (int t = 0; t < 64; t++) issue_check(t, "R9 reload");
    endtask

    task automatic t_load_adv_same(input logic [511:0] blk);
        // done is set from the preceding full block
        block_i = blk;
        cyc(1'b1, 1'b1);
        calc_ref(blk);
        chk(word_vld_o == 1'b0, "R10 vld", 64'(word_vld_o), 64'd0);
        chk(done_o == 1'b0, "R10 done", 64'(done_o), 64'd0);
        issue_check(0, "R10 first");
        issue_check(1, "R10 second");
        block_i = mk_block(32'h0bad_beef);
        cyc(1'b1, 1'b1);
        calc_ref(block_i);
        chk(word_vld_o == 1'b0, "R10 mid vld", 64'(word_vld_o), 64'd0);
        issue_check(0, "R10 restart");
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_before_load();
        t_full_block({32'h61626380, 416'd0, 64'd24});
        t_after_done();
        t_gapped(mk_block(32'h9e37_79b9));
        t_full_block('0);
        t_full_block({16{32'hffff_ffff}});
        t_mid_reload();
        t_load_adv_same(mk_block(32'h5a5a_0001));
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule